// File: doc/BRIEF.md
# Configurable Programmable Logic Array Core

This block is a sum-of-products logic engine whose AND plane, OR plane and output polarity are all defined by configuration bits held in registers. Each input reaches every product term in true and complemented form. Each product term is the AND of whichever literals its configuration selects. Each output is the OR of whichever product terms its configuration selects, so one term can serve several outputs at once. A final per-output XOR with a polarity bit makes each output active-high or active-low.

Configuration arrives one bit per clock on a serial port into a staging shift register. A separate load strobe copies the staged pattern into the active register that drives the planes. Because of this, the logic path never sees a half-shifted pattern. The path from data inputs to data outputs is purely combinational. The number of inputs, product terms and outputs are parameters.

Top module: `pla_core`

## Requirements
- R1: The configuration word is `CFG_W = N_OUT + N_OUT*N_TERM + 2*N_IN*N_TERM` bits wide. Bit `o` (for o < N_OUT) is the polarity of output o. Bit `N_OUT + o*N_TERM + t` connects term t to output o. Bit `N_OUT + N_OUT*N_TERM + t*2*N_IN + 2*i` selects the true literal of input i in term t, and the bit one above it selects the complemented literal.
- R2: An input whose true and complemented selects are both clear in a term is a don't-care for that term.
- R3: A term with no literal selected evaluates to 0 and contributes to no output.
- R4: A term that selects both the true and complemented literal of the same input evaluates to 0.
- R5: Each output's pre-polarity value is the OR of its selected terms. A single term may feed several outputs at the same time.
- R6: Each output equals its OR result XORed with its polarity bit.
- R7: While `cfg_en` is high, each clock shifts the staging register up by one, with `cfg_bit` entering bit 0; the bit shifted first ends at bit CFG_W-1. While `cfg_en` is low, the staging register holds its value.
- R8: The active configuration changes only on a clock with `cfg_load` high, when it takes the staging register's pre-edge value. This holds even if `cfg_en` is high in the same cycle. Shifting without a load leaves `dout` unchanged.
- R9: Asserting `rst_n` low clears both registers at once, without waiting for a clock. Every output then equals its polarity bit, which is 0.
- R10: `dout` follows `din` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Shift-enable for the staging register |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copies staging register into the active configuration |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Logic outputs |

## Verification
The bench builds the core with 3 inputs, 5 product terms and 2 outputs, giving a 42-bit configuration word. At this size every input combination can be applied under each configuration. A random configuration then sets empty terms, conflicting literals and shared terms often enough to be exercised. Directed patterns cover term sharing, both polarities, a partial shift without a load, a load coinciding with a shift, and a reset applied between clock edges.

// File: rtl/pla_core_pkg.sv
package pla_core_pkg;

  // Offset of the OR-plane field inside the configuration word.
  function automatic int unsigned or_base(int unsigned n_out);
    return n_out;
  endfunction

  // Offset of the AND-plane field inside the configuration word.
  function automatic int unsigned and_base(int unsigned n_out, int unsigned n_term);
    return n_out + n_out * n_term;
  endfunction

  // Total configuration width.
  function automatic int unsigned cfg_width(int unsigned n_in, int unsigned n_term,
                                            int unsigned n_out);
    return n_out + n_out * n_term + 2 * n_in * n_term;
  endfunction

endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             cfg_load,
  output logic [CFG_W-1:0] cfg_active
);

  logic [CFG_W-1:0] stage_q, stage_d;
  logic [CFG_W-1:0] active_q, active_d;

  always_comb begin
    stage_d  = stage_q;
    active_d = active_q;
    if (cfg_en)   stage_d  = {stage_q[CFG_W-2:0], cfg_bit};
    if (cfg_load) active_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      stage_q  <= stage_d;
      active_q <= active_d;
    end
  end

  assign cfg_active = active_q;

  // R7
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (stage_q[0] == $past(cfg_bit)) && (stage_q[CFG_W-1:1] == $past(stage_q[CFG_W-2:0])));

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(stage_q));

  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (active_q == $past(stage_q)));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(active_q));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          din,
  input  logic [2*N_IN*N_TERM-1:0] and_cfg,
  output logic [N_TERM-1:0]        pterm
);

  localparam int unsigned ROW_W = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_W-1:0] row;
    logic [N_IN-1:0]  sel_true, sel_comp, lit_ok;
    logic             any_sel;

    assign row = and_cfg[t*ROW_W +: ROW_W];

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign sel_true[i] = row[2*i];
      assign sel_comp[i] = row[2*i+1];
      assign lit_ok[i]   = (!sel_true[i] || din[i]) && (!sel_comp[i] || !din[i]);
    end

    assign any_sel  = |row;
    assign pterm[t] = any_sel && (&lit_ok);

    // R4
    conflict_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sel_true & sel_comp)) |-> !pterm[t]);

    // R2
    dont_care_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pterm[t] |-> (((din & sel_comp) == '0) && ((~din & sel_true) == '0)));
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TERM-1:0]       pterm,
  input  logic [N_OUT*N_TERM-1:0] or_cfg,
  input  logic [N_OUT-1:0]        polarity,
  output logic [N_OUT-1:0]        dout
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] conn;
    logic              sum;

    assign conn    = or_cfg[o*N_TERM +: N_TERM];
    assign sum     = |(conn & pterm);
    assign dout[o] = sum ^ polarity[o];

    // R6
    idle_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((conn & pterm) == '0) |-> (dout[o] == polarity[o]));

    // R5
    active_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((conn & pterm) != '0) |-> (dout[o] != polarity[o]));
  end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  input  logic              cfg_load,
  input  logic [N_IN-1:0]   din,
  output logic [N_OUT-1:0]  dout
);

  import pla_core_pkg::*;

  localparam int unsigned CFG_W   = cfg_width(N_IN, N_TERM, N_OUT);
  localparam int unsigned OR_LO   = or_base(N_OUT);
  localparam int unsigned AND_LO  = and_base(N_OUT, N_TERM);
  localparam int unsigned OR_W    = N_OUT * N_TERM;
  localparam int unsigned AND_W   = 2 * N_IN * N_TERM;

  logic             rst_n_sync;
  logic [CFG_W-1:0] cfg_active;
  logic [N_TERM-1:0] pterm;

  pla_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pla_cfg_store #(.CFG_W(CFG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cfg_en     (cfg_en),
    .cfg_bit    (cfg_bit),
    .cfg_load   (cfg_load),
    .cfg_active (cfg_active)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .din     (din),
    .and_cfg (cfg_active[AND_LO +: AND_W]),
    .pterm   (pterm)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pterm    (pterm),
    .or_cfg   (cfg_active[OR_LO +: OR_W]),
    .polarity (cfg_active[N_OUT-1:0]),
    .dout     (dout)
  );

  // R9
  reset_out_chk: assert property (@(posedge clk)
    !rst_n_sync |-> (dout == '0));

endmodule

// File: tb/pla_core_test.sv
module pla_core_test;

  localparam int NI = 3;
  localparam int NT = 5;
  localparam int NO = 2;
  localparam int W  = NO + NO * NT + 2 * NI * NT;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_bit;
  logic          cfg_load;
  logic [NI-1:0] din;
  logic [NO-1:0] dout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [W-1:0] cfg_a, cfg_b, cfg_c;

  always #2 clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_load(cfg_load), .din(din), .dout(dout)
  );

  function automatic int idx_or(int o, int t);
    return NO + o * NT + t;
  endfunction

  function automatic int idx_lit(int t, int i, bit comp);
    return NO + NO * NT + t * 2 * NI + 2 * i + (comp ? 1 : 0);
  endfunction

  // Expected outputs from the requirement text (R1-style layout, R2..R6 semantics).
  function automatic logic [NO-1:0] model(logic [W-1:0] c, logic [NI-1:0] x);
    logic [NO-1:0] y;
    for (int o = 0; o < NO; o++) begin
      bit acc = 1'b0;
      for (int t = 0; t < NT; t++) begin
        bit used = 1'b0;
        bit true_all = 1'b1;
        for (int i = 0; i < NI; i++) begin
          bit st = c[idx_lit(t, i, 1'b0)];
          bit sc = c[idx_lit(t, i, 1'b1)];
          if (st || sc) used = 1'b1;
          if (st && !x[i]) true_all = 1'b0;
          if (sc && x[i])  true_all = 1'b0;
        end
        if (c[idx_or(o, t)] && used && true_all) acc = 1'b1;
      end
      y[o] = acc ^ c[o];
    end
    return y;
  endfunction

  task automatic check(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: din=%b dout=%b expected=%b", req, din, got, exp);
    end
  endtask

  task automatic check_all(string req, logic [W-1:0] c);
    for (int v = 0; v < (1 << NI); v++) begin
      din = v[NI-1:0];
      #1;
      check(req, dout, model(c, din));
    end
  endtask

  task automatic shift_bits(logic [W-1:0] c, int nbits);
    for (int k = W - 1; k >= W - nbits; k--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = c[k];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic load_cfg(logic [W-1:0] c);
    shift_bits(c, W);
    pulse_load();
  endtask

  function automatic logic [W-1:0] rand_cfg();
    logic [W-1:0] c;
    for (int k = 0; k < W; k++) c[k] = $urandom_range(0, 2) == 0;
    return c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, got=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0; cfg_load = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: after reset all-zero config, outputs equal polarity (0)
    check_all("R9 reset state", '0);

    // R1 R2 R5 R6: term0 = in0, term1 = ~in1 & in2; out0 = t0|t1, out1 = t1 inverted
    cfg_a = '0;
    cfg_a[idx_lit(0, 0, 1'b0)] = 1'b1;
    cfg_a[idx_lit(1, 1, 1'b1)] = 1'b1;
    cfg_a[idx_lit(1, 2, 1'b0)] = 1'b1;
    cfg_a[idx_or(0, 0)] = 1'b1;
    cfg_a[idx_or(0, 1)] = 1'b1;
    cfg_a[idx_or(1, 1)] = 1'b1;
    cfg_a[1] = 1'b1;
    load_cfg(cfg_a);
    check_all("R1 R2 R5 R6 directed", cfg_a);

    // R3 R4: empty term on out0, conflicting term on out1 (polarity 1)
    cfg_b = '0;
    cfg_b[idx_or(0, 0)] = 1'b1;
    cfg_b[idx_lit(2, 1, 1'b0)] = 1'b1;
    cfg_b[idx_lit(2, 1, 1'b1)] = 1'b1;
    cfg_b[idx_or(1, 2)] = 1'b1;
    cfg_b[1] = 1'b1;
    load_cfg(cfg_b);
    for (int v = 0; v < (1 << NI); v++) begin
      din = v[NI-1:0];
      #1;
      check("R3 empty term", dout[0], 1'b0);
      check("R4 conflict term", dout[1], 1'b1);
    end

    // R8: partial shift without load leaves outputs unchanged
    cfg_c = rand_cfg();
    shift_bits(cfg_c, W / 2);
    check_all("R8 partial shift no load", cfg_b);

    // R7: cfg_en low ignores cfg_bit toggling; then load full pattern
    shift_bits(cfg_c, W);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_bit = k[0];
    end
    pulse_load();
    check_all("R7 hold when disabled", cfg_c);

    // R8: load in same cycle as shift takes pre-shift value
    cfg_a = rand_cfg();
    shift_bits(cfg_a, W);
    cfg_en = 1'b1; cfg_bit = 1'b1; cfg_load = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0; cfg_load = 1'b0;
    check_all("R8 load with shift", cfg_a);
    // R7: staging register moved one place with the 1 at bit 0
    pulse_load();
    check_all("R7 one-bit shift", {cfg_a[W-2:0], 1'b1});

    // R5 R6 R10: random configurations, exhaustive inputs
    for (int n = 0; n < 25; n++) begin
      cfg_c = rand_cfg();
      load_cfg(cfg_c);
      check_all("R10 R5 R6 random", cfg_c);
    end

    // R9: asynchronous reset between edges clears active configuration
    cfg_c = '0;
    cfg_c[idx_or(0, 0)] = 1'b1;
    cfg_c[0] = 1'b1;
    load_cfg(cfg_c);
    #1;
    rst_n = 1'b0;
    #0.5;
    check_all("R9 async reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9 after reset release", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule